// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller. It serves several banks of pins (four banks of 32 by default) through a flat 32-bit register bus made of an address, a write strobe, write data and combinational read data. Each pin has three separate signals: an input, an output value and an output enable. Every bank has direction and output-data control, per-pin rising and falling edge detection, a pending-edge status word, and a per-pin interrupt enable word. Direction, output data and both edge-enable words have dedicated write-only set and clear ports. Software can change individual bits through these ports without a read-modify-write.

Pin inputs pass through a synchronizer before they are read back or checked for edges. A single interrupt line reports whether any bank holds a pending edge on a pin whose interrupt enable bit is 1. The controller sits between the pad ring and a bus bridge. Software enables the edges it needs, enables those pins in the bank's interrupt word, services the line by reading the status word, and then clears the bits it has handled by writing ones back.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero and `irq` is low.
- R2: Bank bases are 0x000, 0x004, 0x008 and 0x100. Registers are placed at base + 12·k, where k is: 0 level (read-only), 1 direction, 2 output-set, 3 output-clear, 4 rise-enable, 5 fall-enable, 6 status, 7 direction-set, 8 direction-clear, 9 rise-set, 10 rise-clear, 11 fall-set, 12 fall-clear, 13 interrupt-enable. Bank b owns bits 32·b to 32·b+31 of each pin vector.
- R3: A one written to a set port sets the matching bit of its target, and a one written to a clear port clears it. Zero bits leave the target as it was. All set and clear ports read as zero.
- R4: `pin_oe` equals the direction register (1 = output), and `pin_out` equals the output-data register. Both change on the clock edge that takes the write.
- R5: The level register returns `pin_in` delayed by two clock edges through the synchronizer, whatever the pin's direction.
- R6: With rise-enable set, a 0→1 change on a synchronized pin sets its status bit. With fall-enable set, a 1→0 change does the same. With both set, either change does it. The bit becomes readable after the third clock edge that follows the pin change.
- R7: Writing the status register clears each bit written as one and keeps every bit written as zero.
- R8: When an edge is detected in the same cycle that a write clears that status bit, the bit stays set.
- R9: `irq` is the OR over all banks of (status AND interrupt-enable), registered, so it follows that value one cycle later. An all-zero interrupt-enable word keeps its bank from raising `irq`.
- R10: A read from an address that maps to no register returns zero, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 10 | Byte address of the register |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 128 | Pin input levels, bank-major |
| pin_out | output | 128 | Pin output values |
| pin_oe | output | 128 | Pin output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The edge logic is driven with single rising changes, single falling changes, and pulses on pins that have one or both enables set. These patterns separate the rise, fall and both-edge behaviour, and they show the three-edge latency. A clear is aligned with a fresh edge to expose the priority between the two. Set and clear writes use overlapping bit patterns, so a port that writes the whole word instead of its ones is caught. The interleaved and high bank addresses are exercised, together with unmapped addresses that lie between them, which catches decode aliasing. The interrupt-enable word is toggled while status bits stay pending, which shows that the enable gates `irq` and does not drop the pending state.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

   localparam int NUM_SLOTS = 14;
   localparam int SLOT_W    = $clog2(NUM_SLOTS);

   // Register slot index within a bank (address = base + stride * slot)
   typedef enum logic [SLOT_W-1:0] {
      SL_LEVEL = 4'd0,
      SL_DIR   = 4'd1,
      SL_OSET  = 4'd2,
      SL_OCLR  = 4'd3,
      SL_RISE  = 4'd4,
      SL_FALL  = 4'd5,
      SL_STAT  = 4'd6,
      SL_DSET  = 4'd7,
      SL_DCLR  = 4'd8,
      SL_RSET  = 4'd9,
      SL_RCLR  = 4'd10,
      SL_FSET  = 4'd11,
      SL_FCLR  = 4'd12,
      SL_IEN   = 4'd13
   } slot_e;

   // Base byte offset of bank b: three interleaved low banks, then a high one
   function automatic int bank_base(input int b);
      return (b < 3) ? b * 4 : 32'h100 + (b - 3) * 4;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_ctrl_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int BASE   = 0,
   parameter int STRIDE = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output slot_e             slot_o
);

   localparam int SPAN = STRIDE * NUM_SLOTS;

   if (STRIDE < 4 || (STRIDE % 4) != 0) begin : g_bad_stride
      $error("gpio_addr_dec: STRIDE must be a word multiple");
   end

   logic [ADDR_W-1:0] off;

   always_comb begin
      off    = addr_i - ADDR_W'(BASE);
      hit_o  = (addr_i >= ADDR_W'(BASE)) && (off < ADDR_W'(SPAN))
               && ((off % ADDR_W'(STRIDE)) == '0);
      slot_o = slot_e'(SLOT_W'(off / ADDR_W'(STRIDE)));
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_ctrl_pkg::*;
#(
   parameter int PINS        = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hit_i,
   input  slot_e           slot_i,
   input  logic            we_i,
   input  logic [PINS-1:0] wdata_i,
   output logic [PINS-1:0] rdata_o,
   input  logic [PINS-1:0] pin_i,
   output logic [PINS-1:0] pin_o,
   output logic [PINS-1:0] oe_o,
   output logic            pend_o
);

   logic [PINS-1:0] lvl, prev_q;
   logic [PINS-1:0] out_q, dir_q, rise_q, fall_q, stat_q, ien_q;
   logic [PINS-1:0] edge_hits, stat_clr;
   logic            wr;

   gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pin_i),
      .q_o (lvl)
   );

   assign wr = we_i && hit_i;

   always_comb begin
      edge_hits = (lvl & ~prev_q & rise_q) | (~lvl & prev_q & fall_q);
      stat_clr  = (wr && slot_i == SL_STAT) ? wdata_i : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         out_q  <= '0;
         dir_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         stat_q <= '0;
         ien_q  <= '0;
      end else begin
         prev_q <= lvl;
         stat_q <= (stat_q & ~stat_clr) | edge_hits;
         if (wr) begin
            case (slot_i)
               SL_OSET: out_q  <= out_q | wdata_i;
               SL_OCLR: out_q  <= out_q & ~wdata_i;
               SL_DIR:  dir_q  <= wdata_i;
               SL_DSET: dir_q  <= dir_q | wdata_i;
               SL_DCLR: dir_q  <= dir_q & ~wdata_i;
               SL_RISE: rise_q <= wdata_i;
               SL_RSET: rise_q <= rise_q | wdata_i;
               SL_RCLR: rise_q <= rise_q & ~wdata_i;
               SL_FALL: fall_q <= wdata_i;
               SL_FSET: fall_q <= fall_q | wdata_i;
               SL_FCLR: fall_q <= fall_q & ~wdata_i;
               SL_IEN:  ien_q  <= wdata_i;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_i) begin
         case (slot_i)
            SL_LEVEL: rdata_o = lvl;
            SL_DIR:   rdata_o = dir_q;
            SL_RISE:  rdata_o = rise_q;
            SL_FALL:  rdata_o = fall_q;
            SL_STAT:  rdata_o = stat_q;
            SL_IEN:   rdata_o = ien_q;
            default:  rdata_o = '0;
         endcase
      end
   end

   assign pin_o  = out_q;
   assign oe_o   = dir_q;
   assign pend_o = |(stat_q & ien_q);

   // Status only moves on a detected edge or a clear write
   assert_stat_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (stat_clr == '0 && edge_hits == '0) |=> stat_q == $past(stat_q));

   // A fresh edge wins over a clear of the same bit
   assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
      ((edge_hits & stat_clr) != '0) |=>
         ((stat_q & $past(edge_hits & stat_clr)) == $past(edge_hits & stat_clr)));

   // A direction-set write leaves every written one set
   assert_dir_set_R3: assert property (@(posedge clk) disable iff (rst)
      (wr && slot_i == SL_DSET) |=> ((dir_q & $past(wdata_i)) == $past(wdata_i)));

   // A direction-clear write leaves every written one cleared
   assert_dir_clr_R3: assert property (@(posedge clk) disable iff (rst)
      (wr && slot_i == SL_DCLR) |=> ((dir_q & $past(wdata_i)) == '0));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
   import gpio_ctrl_pkg::*;
#(
   parameter int BANKS       = 4,
   parameter int PINS        = 32,
   parameter int ADDR_W      = 10,
   parameter int STRIDE      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [ADDR_W-1:0]     addr,
   input  logic                  we,
   input  logic [PINS-1:0]       wdata,
   output logic [PINS-1:0]       rdata,
   input  logic [BANKS*PINS-1:0] pin_in,
   output logic [BANKS*PINS-1:0] pin_out,
   output logic [BANKS*PINS-1:0] pin_oe,
   output logic                  irq
);

   localparam int TOP_ADDR = bank_base(BANKS - 1) + STRIDE * (NUM_SLOTS - 1);

   if (BANKS < 1 || BANKS > 4) begin : g_bad_banks
      $error("gpio_edge_ctrl: BANKS must be 1 to 4");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("gpio_edge_ctrl: ADDR_W too narrow for the register map");
   end
   if (PINS < 1 || PINS > 32) begin : g_bad_pins
      $error("gpio_edge_ctrl: PINS must be 1 to 32");
   end

   logic [PINS-1:0] bank_rd [BANKS];
   logic [BANKS-1:0] bank_hit, bank_pend;
   logic             pend_any;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      slot_e slot;

      gpio_addr_dec #(
         .ADDR_W (ADDR_W),
         .BASE   (bank_base(b)),
         .STRIDE (STRIDE)
      ) i_dec (
         .addr_i (addr),
         .hit_o  (bank_hit[b]),
         .slot_o (slot)
      );

      gpio_bank #(
         .PINS        (PINS),
         .SYNC_STAGES (SYNC_STAGES)
      ) i_bank (
         .clk     (clk),
         .rst     (rst),
         .hit_i   (bank_hit[b]),
         .slot_i  (slot),
         .we_i    (we),
         .wdata_i (wdata),
         .rdata_o (bank_rd[b]),
         .pin_i   (pin_in[b*PINS +: PINS]),
         .pin_o   (pin_out[b*PINS +: PINS]),
         .oe_o    (pin_oe[b*PINS +: PINS]),
         .pend_o  (bank_pend[b])
      );
   end

   always_comb begin
      rdata = '0;
      for (int b = 0; b < BANKS; b++) rdata = rdata | bank_rd[b];
   end

   assign pend_any = |bank_pend;

   always_ff @(posedge clk) begin
      if (rst) irq <= 1'b0;
      else     irq <= pend_any;
   end

   // At most one bank answers any address
   always_comb begin
      assert_single_bank_R2: assert ($onehot0(bank_hit));
   end

   // Unmapped addresses read as zero
   always_comb begin
      if (bank_hit == '0) begin
         assert_unmapped_zero_R10: assert (rdata == '0);
      end
   end

   assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> irq == $past(pend_any));

endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int NP = 32;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [9:0]       addr = '0;
   logic             we = 1'b0;
   logic [31:0]      wdata = '0;
   logic [31:0]      rdata;
   logic [NB*NP-1:0] pin_in = '0;
   logic [NB*NP-1:0] pin_out;
   logic [NB*NP-1:0] pin_oe;
   logic             irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   gpio_edge_ctrl i_gpio_edge_ctrl (
      .clk     (clk),
      .rst     (rst),
      .addr    (addr),
      .we      (we),
      .wdata   (wdata),
      .rdata   (rdata),
      .pin_in  (pin_in),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .irq     (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- reference model ----------------
   logic [31:0] m_out [NB], m_dir [NB], m_rise [NB], m_fall [NB];
   logic [31:0] m_stat [NB], m_ien [NB], m_s1 [NB], m_s2 [NB], m_prev [NB];
   logic        m_irq;

   function automatic bit mdec(input int a, input int b, output int k);
      int base, off;
      base = (b < 3) ? b * 4 : 256;
      off  = a - base;
      k    = 0;
      if (off < 0 || (off % 12) != 0) return 1'b0;
      k = off / 12;
      return (k <= 13);
   endfunction

   function automatic logic [31:0] mread(input int a);
      int k;
      for (int b = 0; b < NB; b++) begin
         if (mdec(a, b, k)) begin
            case (k)
               0:  return m_s2[b];
               1:  return m_dir[b];
               4:  return m_rise[b];
               5:  return m_fall[b];
               6:  return m_stat[b];
               13: return m_ien[b];
               default: return 32'h0;
            endcase
         end
      end
      return 32'h0;
   endfunction

   always @(posedge clk) begin
      logic [31:0] hits [NB];
      logic [31:0] clr;
      logic        nirq;
      int k;
      if (rst) begin
         for (int b = 0; b < NB; b++) begin
            m_out[b] = 0; m_dir[b] = 0; m_rise[b] = 0; m_fall[b] = 0;
            m_stat[b] = 0; m_ien[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
         end
         m_irq = 1'b0;
      end else begin
         nirq = 1'b0;
         for (int b = 0; b < NB; b++) begin
            hits[b] = (m_s2[b] & ~m_prev[b] & m_rise[b]) | (~m_s2[b] & m_prev[b] & m_fall[b]);
            if ((m_stat[b] & m_ien[b]) != 0) nirq = 1'b1;
         end
         m_irq = nirq;
         for (int b = 0; b < NB; b++) begin
            clr = 0;
            if (we && mdec(int'(addr), b, k)) begin
               case (k)
                  1:  m_dir[b]  = wdata;
                  2:  m_out[b]  = m_out[b] | wdata;
                  3:  m_out[b]  = m_out[b] & ~wdata;
                  4:  m_rise[b] = wdata;
                  5:  m_fall[b] = wdata;
                  6:  clr = wdata;
                  7:  m_dir[b]  = m_dir[b] | wdata;
                  8:  m_dir[b]  = m_dir[b] & ~wdata;
                  9:  m_rise[b] = m_rise[b] | wdata;
                  10: m_rise[b] = m_rise[b] & ~wdata;
                  11: m_fall[b] = m_fall[b] | wdata;
                  12: m_fall[b] = m_fall[b] & ~wdata;
                  13: m_ien[b]  = wdata;
                  default: ;
               endcase
            end
            m_stat[b] = (m_stat[b] & ~clr) | hits[b];
            m_prev[b] = m_s2[b];
            m_s2[b]   = m_s1[b];
            m_s1[b]   = pin_in[b*NP +: NP];
         end
      end
   end

   // Per-clock comparison of registered outputs (R4, R9)
   always @(negedge clk) begin
      logic [NB*NP-1:0] e_out, e_oe;
      if (!rst && !done) begin
         for (int b = 0; b < NB; b++) begin
            e_out[b*NP +: NP] = m_out[b];
            e_oe[b*NP +: NP]  = m_dir[b];
         end
         checks += 3;
         if (pin_out !== e_out) begin
            fails++; $display("FAIL R4 pin_out act=%h exp=%h", pin_out, e_out);
         end
         if (pin_oe !== e_oe) begin
            fails++; $display("FAIL R4 pin_oe act=%h exp=%h", pin_oe, e_oe);
         end
         if (irq !== m_irq) begin
            fails++; $display("FAIL R9 irq act=%b exp=%b", irq, m_irq);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      addr = 10'(a); we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   // Read, compare to model and to an independent literal
   task automatic rd(input int a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      addr = 10'(a); we = 1'b0;
      #1;
      chk(rdata, mread(a), {tag, " model"});
      chk(rdata, exp, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_pins(input int b, input logic [31:0] v);
      @(negedge clk);
      pin_in[b*NP +: NP] = v;
   endtask

   // ---------------- stimulus ----------------
   initial begin
      idle(3);
      rst = 1'b0;
      idle(1);

      // R1: reset state
      chk(irq, 0, "R1 irq");
      chk(pin_oe[31:0], 0, "R1 oe");
      for (int b = 0; b < NB; b++) begin
         int base;
         base = (b < 3) ? b * 4 : 256;
         rd(base + 12, 0, "R1 dir");
         rd(base + 156, 0, "R1 ien");
         rd(base + 72, 0, "R1 stat");
      end

      // R2/R4: output data and direction per bank, using interleaved bases
      wr(12'h018, 32'hA5A5_0001);        // bank0 output set
      wr(12'h01C, 32'h0000_FF00);        // bank1 output set
      wr(12'h020, 32'h1234_5678);        // bank2 output set
      wr(12'h118, 32'h8000_0001);        // bank3 output set
      wr(12'h10C, 32'hCAFE_0000);        // bank3 direction direct
      chk(pin_out[127:96], 32'h8000_0001, "R2 bank3 out");
      chk(pin_out[63:32], 32'h0000_FF00, "R2 bank1 out");
      chk(pin_oe[127:96], 32'hCAFE_0000, "R4 bank3 oe");
      rd(12'h10C, 32'hCAFE_0000, "R2 bank3 dir");
      rd(12'h00C, 0, "R2 bank0 dir untouched");

      // R3: set/clear with overlapping patterns
      wr(12'h054, 32'h0000_F0F0);        // bank0 dir set
      wr(12'h060, 32'h0000_00F0);        // bank0 dir clear
      rd(12'h00C, 32'h0000_F000, "R3 dir set/clr");
      wr(12'h024, 32'h0000_0001);        // bank0 output clear
      chk(pin_out[31:0], 32'hA5A5_0000, "R3 out clr");
      wr(12'h070, 32'h0000_000F);        // bank1 rise set
      wr(12'h07C, 32'h0000_0003);        // bank1 rise clear
      rd(12'h034, 32'h0000_000C, "R3 rise set/clr");
      wr(12'h088, 32'h0000_0030);        // bank1 fall set
      wr(12'h094, 32'h0000_0010);        // bank1 fall clear
      rd(12'h040, 32'h0000_0020, "R3 fall set/clr");
      rd(12'h054, 0, "R3 set port reads zero");
      rd(12'h094, 0, "R3 clear port reads zero");

      // R5: level readback after two edges
      set_pins(2, 32'hDEAD_BEEF);
      idle(2);
      rd(12'h008, 32'hDEAD_BEEF, "R5 level bank2");
      set_pins(0, 32'h0000_F000);        // pins that are outputs still read
      idle(2);
      rd(12'h000, 32'h0000_F000, "R5 level output pins");

      // R6: bank1 rise on bits 2,3 ; fall on bit 5 ; both on bit 8
      wr(12'h070, 32'h0000_0100);
      wr(12'h088, 32'h0000_0100);
      set_pins(1, 32'h0000_0024);        // bits 2,5 rise
      idle(3);
      rd(12'h04C, 32'h0000_0004, "R6 rise only");
      set_pins(1, 32'h0000_0000);        // bits 2,5 fall
      idle(3);
      rd(12'h04C, 32'h0000_0024, "R6 fall only");
      set_pins(1, 32'h0000_0100);        // bit 8 rise
      idle(3);
      rd(12'h04C, 32'h0000_0124, "R6 both rise");

      // R7: partial write-one-to-clear
      wr(12'h04C, 32'h0000_0104);
      rd(12'h04C, 32'h0000_0020, "R7 w1c partial");
      set_pins(1, 32'h0000_0000);        // bit 8 fall
      idle(3);
      rd(12'h04C, 32'h0000_0120, "R6 both fall");

      // R8: clear coinciding with a new edge on bit 8
      set_pins(1, 32'h0000_0100);
      @(negedge clk);
      wr(12'h04C, 32'h0000_0120);        // active on the edge-detect clock
      rd(12'h04C, 32'h0000_0100, "R8 edge beats clear");

      // R9: interrupt enable gating
      idle(2);
      chk(irq, 0, "R9 irq masked");
      wr(12'h0A0, 32'h0000_0100);        // bank1 interrupt enable
      idle(1);
      chk(irq, 1, "R9 irq raised");
      wr(12'h0A0, 32'h0000_0000);
      idle(1);
      chk(irq, 0, "R9 mask zero suppresses");
      rd(12'h04C, 32'h0000_0100, "R9 status kept");
      wr(12'h0A0, 32'hFFFF_FFFF);
      wr(12'h04C, 32'hFFFF_FFFF);
      idle(1);
      chk(irq, 0, "R9 irq after clear");

      // R10: unmapped addresses
      wr(12'h0B0, 32'hFFFF_FFFF);
      wr(12'h002, 32'hFFFF_FFFF);
      wr(12'h1A0, 32'hFFFF_FFFF);
      wr(12'h3FC, 32'hFFFF_FFFF);
      rd(12'h0B0, 0, "R10 unmapped read");
      rd(12'h1A0, 0, "R10 unmapped read high");
      rd(12'h00C, 32'h0000_F000, "R10 bank0 dir intact");
      rd(12'h10C, 32'hCAFE_0000, "R10 bank3 dir intact");
      rd(12'h19C, 0, "R10 bank3 ien intact");
      idle(4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule